// File: doc/BRIEF.md
# Byte Data Register with Fall-Through Transmit and Receive FIFOs

This block puts one 8-bit data register in front of two independent byte queues. A bus write loads the top stage of the transmit queue. A bus read returns the bottom stage of the receive queue and removes it. Each queue is a chain of stages, and each stage has its own valid flag. A byte entered at the top sinks one stage per clock until it reaches the lowest free stage. When the bottom stage is emptied, every byte above it moves down behind it.

The serial side works through two valid/ready streams:

- **Transmit stream.** It offers the bottom transmit byte to a serial shifter. A byte leaves on a cycle where valid and ready are both high. Valid never waits on ready. Valid is held low while the block is disabled.
- **Receive stream.** A producer offers incoming bytes at the top of the receive queue. Ready depends only on the enable bit and on whether the top stage is occupied. A producer that ignores ready loses the byte, and the loss is recorded in a sticky overrun flag.

A write of zero to the enable bit empties both queues and clears the overrun flag. This also happens when the block is already disabled. After that, software may prime up to 16 transmit bytes before it sets the enable bit. Setting the enable bit keeps every byte that is queued.

Top module: `dreg_fifo_pair`

## Requirements
- R1: After reset the block has the following state: `enabled` = 0, `tx_full` = 0, `rx_empty` = 1, `bus_rd_data` = 0, `tx_out_valid` = 0, `rx_in_ready` = 0 and `rx_overrun` = 0.
- R2: The transmit write port works as follows.
  - `tx_full` is 1 exactly when the top transmit stage holds a byte.
  - A `bus_wr_en` pulse while `tx_full` = 0 stores `bus_wr_data` at the clock edge.
  - A pulse while `tx_full` = 1 is dropped.
  - Once 16 bytes have settled, `tx_full` stays 1.
- R3: Every queued byte moves down one stage per clock while the stage below is free. A byte accepted into an empty 16-stage queue reaches the bottom on the 16th rising edge, counting the accepting edge as the first. For the transmit queue this shows as `tx_out_valid` = 1 when enabled. For the receive queue it shows as `rx_empty` = 0.
- R4: Both queues deliver bytes in the order they were accepted, with none lost or repeated.
- R5: The transmit stream handshake works as follows.
  - `tx_out_valid` is 1 when the block is enabled and the bottom transmit stage is occupied.
  - `tx_out_data` stays constant until a cycle with `tx_out_ready` = 1.
  - That handshake removes exactly one byte.
- R6: While disabled, `tx_out_valid` stays 0 and primed transmit bytes are kept. After the enable bit is set, those bytes leave in order.
- R7: `rx_in_ready` is 1 when the block is enabled and the top receive stage is free. `rx_in_data` is accepted on an edge where `rx_in_valid` and `rx_in_ready` are both 1.
- R8: The overrun flag behaves as follows.
  - A receive byte offered while enabled and `rx_in_ready` = 0 is dropped and sets `rx_overrun`.
  - `rx_overrun` then stays 1 until the queues are cleared.
  - While disabled, offers are ignored and do not set the flag.
- R9: `bus_rd_data` shows the bottom receive byte when `rx_empty` = 0, and 0 otherwise. A `bus_rd_en` pulse removes that byte only if `rx_empty` = 0.
- R10: The enable port works as follows.
  - An `en_wr` pulse with `en_wdata` = 0 clears `enabled`, both queues and `rx_overrun` at that edge.
  - Any write or receive push in the same cycle is lost.
  - An `en_wr` pulse with `en_wdata` = 1 sets `enabled` and keeps all queued bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | New enable value; 0 also clears both queues |
| enabled | output | 1 | Current enable bit |
| bus_wr_en | input | 1 | Data register write strobe |
| bus_wr_data | input | 8 | Byte written into the transmit top stage |
| tx_full | output | 1 | Top transmit stage occupied; writes are dropped |
| bus_rd_en | input | 1 | Data register read strobe, pops when not empty |
| bus_rd_data | output | 8 | Bottom receive byte, or 0 when empty |
| rx_empty | output | 1 | Bottom receive stage empty |
| rx_overrun | output | 1 | Sticky flag for a dropped receive byte |
| tx_out_valid | output | 1 | Transmit stream valid |
| tx_out_ready | input | 1 | Transmit stream ready from the serial shifter |
| tx_out_data | output | 8 | Transmit stream byte |
| rx_in_valid | input | 1 | Receive stream valid from the producer |
| rx_in_ready | output | 1 | Receive stream ready |
| rx_in_data | input | 8 | Receive stream byte |

## Verification
These are the port symptoms that different internal faults would produce:

- **Stuck or lost valid flag.** A stage valid flag that sticks or is lost shows at the ports as a missing, repeated or reordered byte. It appears when that byte reaches the bottom, within 16 clocks of entering an empty queue.
- **Wrong latency.** A chain that moves too fast or too slow shifts the edge on which `tx_out_valid` or `rx_empty` changes away from the 16th edge.
- **Broken clear or enable.** A clear or enable that misbehaves shows as primed bytes leaking while disabled, or as bytes that survive a flush. Either is visible within a few dozen clocks of the enable writes.

// File: rtl/dreg_fifo_pkg.sv
package dreg_fifo_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned STAGES_DEF = 16;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ft_chain.sv
// Fall-through queue: stage 0 is the bottom, stage DEPTH-1 the top.
module ft_chain #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  output logic         push_ready,
  input  logic         pop,
  output logic         bot_valid,
  output logic [W-1:0] bot_data
);
  localparam int unsigned TOP = DEPTH - 1;

  logic [DEPTH-1:0]        vld_q;
  logic [DEPTH-1:0][W-1:0] dat_q;
  logic [DEPTH-1:0]        leave;
  logic [DEPTH-1:0]        fill;
  logic [DEPTH-1:0][W-1:0] src;

  // A stage empties when it pops (bottom) or slides into a free or emptying stage.
  always_comb begin
    leave[0] = pop && vld_q[0];
    for (int i = 1; i < DEPTH; i++) begin
      leave[i] = vld_q[i] && (!vld_q[i-1] || leave[i-1]);
    end
  end

  assign push_ready = !vld_q[TOP];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == TOP) begin : g_top
        assign fill[g] = push_valid && !vld_q[TOP];
        assign src[g]  = push_data;
      end else begin : g_mid
        assign fill[g] = leave[g+1];
        assign src[g]  = dat_q[g+1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dat_q <= '0;
    end else if (clear) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (fill[i]) begin
          vld_q[i] <= 1'b1;
          dat_q[i] <= src[i];
        end else if (leave[i]) begin
          vld_q[i] <= 1'b0;
        end
      end
    end
  end

  assign bot_valid = vld_q[0];
  assign bot_data  = dat_q[0];

  // R3
  gap_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !vld_q[0] && vld_q[1]) |=> vld_q[0]);

  // R5
  bottom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && vld_q[0] && !pop) |=> (vld_q[0] && $stable(dat_q[0])));

  // R10
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (vld_q == '0));

  // R2
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && vld_q[TOP] && vld_q[TOP-1] && !leave[TOP-1]) |=> vld_q[TOP]);
endmodule

// File: rtl/dreg_ctrl.sv
module dreg_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr,
  input  logic en_wdata,
  input  logic rx_offer,
  input  logic rx_top_free,
  output logic enabled,
  output logic flush,
  output logic overrun
);
  logic en_q;
  logic ovr_q;

  assign flush = en_wr && !en_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else if (flush) begin
      en_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= 1'b1;
      if (en_q && rx_offer && !rx_top_free) ovr_q <= 1'b1;
    end
  end

  assign enabled = en_q;
  assign overrun = ovr_q;

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !flush) |=> ovr_q);

  // R8
  disabled_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ovr_q) |=> !ovr_q);
endmodule

// File: rtl/dreg_fifo_pair.sv
module dreg_fifo_pair
  import dreg_fifo_pkg::*;
#(
  parameter int unsigned TX_DEPTH = STAGES_DEF,
  parameter int unsigned RX_DEPTH = STAGES_DEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_wr,
  input  logic        en_wdata,
  output logic        enabled,
  input  logic        bus_wr_en,
  input  logic [7:0]  bus_wr_data,
  output logic        tx_full,
  input  logic        bus_rd_en,
  output logic [7:0]  bus_rd_data,
  output logic        rx_empty,
  output logic        rx_overrun,
  output logic        tx_out_valid,
  input  logic        tx_out_ready,
  output logic [7:0]  tx_out_data,
  input  logic        rx_in_valid,
  output logic        rx_in_ready,
  input  logic [7:0]  rx_in_data
);
  logic  flush;
  logic  tx_push_rdy, tx_bot_vld;
  byte_t tx_bot_dat;
  logic  rx_push_rdy, rx_bot_vld;
  byte_t rx_bot_dat;

  dreg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr      (en_wr),
    .en_wdata   (en_wdata),
    .rx_offer   (rx_in_valid),
    .rx_top_free(rx_push_rdy),
    .enabled    (enabled),
    .flush      (flush),
    .overrun    (rx_overrun)
  );

  ft_chain #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush),
    .push_valid(bus_wr_en && !flush),
    .push_data (bus_wr_data),
    .push_ready(tx_push_rdy),
    .pop       (tx_out_valid && tx_out_ready),
    .bot_valid (tx_bot_vld),
    .bot_data  (tx_bot_dat)
  );

  ft_chain #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush),
    .push_valid(rx_in_valid && enabled && !flush),
    .push_data (rx_in_data),
    .push_ready(rx_push_rdy),
    .pop       (bus_rd_en),
    .bot_valid (rx_bot_vld),
    .bot_data  (rx_bot_dat)
  );

  assign tx_full      = !tx_push_rdy;
  assign tx_out_valid = enabled && tx_bot_vld;
  assign tx_out_data  = tx_bot_dat;
  assign rx_in_ready  = enabled && rx_push_rdy;
  assign rx_empty     = !rx_bot_vld;
  assign bus_rd_data  = rx_bot_vld ? rx_bot_dat : '0;

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && !en_wr) |=> !tx_out_valid);

  // R9
  empty_read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && bus_rd_en && !flush) |=> (bus_rd_data == '0 || !rx_empty));
endmodule

// File: tb/test_dreg_fifo_pair.sv
module test_dreg_fifo_pair;
  logic clk = 0, rst_n = 0;
  logic en_wr = 0, en_wdata = 0, enabled;
  logic bus_wr_en = 0; logic [7:0] bus_wr_data = 0; logic tx_full;
  logic bus_rd_en = 0; logic [7:0] bus_rd_data; logic rx_empty, rx_overrun;
  logic tx_out_valid, tx_out_ready = 0; logic [7:0] tx_out_data;
  logic rx_in_valid = 0, rx_in_ready; logic [7:0] rx_in_data = 0;
  int unsigned checks = 0, errors = 0;
  logic [7:0] txq[$], rxq[$];

  always #5 clk = ~clk;

  dreg_fifo_pair i_dreg_fifo_pair (.*);

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tx_write(input logic [7:0] b);
    for (int n = 0; n < 100 && tx_full; n++) @(negedge clk);
    bus_wr_en = 1; bus_wr_data = b;
    @(negedge clk); bus_wr_en = 0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    for (int n = 0; n < 100 && !rx_in_ready; n++) @(negedge clk);
    rx_in_valid = 1; rx_in_data = b;
    @(negedge clk); rx_in_valid = 0;
  endtask

  task automatic set_en(input logic v);
    en_wr = 1; en_wdata = v;
    @(negedge clk); en_wr = 0;
  endtask

  task automatic bus_read(output logic [7:0] b);
    bus_rd_en = 1; b = bus_rd_data;
    @(negedge clk); bus_rd_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int got;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!enabled && !tx_full && rx_empty && !tx_out_valid && !rx_in_ready && !rx_overrun,
        "R1 reset flags", {enabled, tx_full, rx_empty, tx_out_valid, rx_in_ready, rx_overrun}, 6'b001000);
    chk(bus_rd_data == 0, "R1 read data", bus_rd_data, 0);

    // R2/R6 priming while disabled
    for (int i = 0; i < 16; i++) tx_write(pat(i));
    repeat (20) @(negedge clk);
    chk(tx_full == 1, "R2 full after 16", tx_full, 1);
    chk(tx_out_valid == 0, "R6 quiet while disabled", tx_out_valid, 0);
    bus_wr_en = 1; bus_wr_data = 8'hEE; @(negedge clk); bus_wr_en = 0;
    set_en(1);
    chk(enabled == 1, "R10 enable set", enabled, 1);
    tx_out_ready = 1; got = 0;
    for (int c = 0; c < 80; c++) begin
      if (tx_out_valid) begin
        chk(got < 16 && tx_out_data == pat(got), "R4 R6 primed order", tx_out_data, pat(got));
        got++;
      end
      @(negedge clk);
    end
    tx_out_ready = 0;
    chk(got == 16, "R2 dropped write not sent", got, 16);

    // R3 transmit latency
    bus_wr_en = 1; bus_wr_data = 8'h5A;
    @(posedge clk); @(negedge clk); bus_wr_en = 0;
    repeat (14) @(posedge clk); @(negedge clk);
    chk(tx_out_valid == 0, "R3 tx not yet at bottom", tx_out_valid, 0);
    @(posedge clk); @(negedge clk);
    chk(tx_out_valid == 1 && tx_out_data == 8'h5A, "R3 tx at bottom on 16th edge", tx_out_data, 8'h5A);
    repeat (10) @(negedge clk);
    chk(tx_out_valid == 1 && tx_out_data == 8'h5A, "R5 held without ready", tx_out_data, 8'h5A);
    tx_out_ready = 1; @(negedge clk); tx_out_ready = 0;
    chk(tx_out_valid == 0, "R5 one handshake removes one", tx_out_valid, 0);

    // R3 receive latency, R9 read
    rx_in_valid = 1; rx_in_data = 8'hC3;
    @(posedge clk); @(negedge clk); rx_in_valid = 0;
    repeat (14) @(posedge clk); @(negedge clk);
    chk(rx_empty == 1, "R3 rx not yet at bottom", rx_empty, 1);
    @(posedge clk); @(negedge clk);
    chk(rx_empty == 0 && bus_rd_data == 8'hC3, "R3 R9 rx at bottom", bus_rd_data, 8'hC3);
    bus_read(b);
    chk(b == 8'hC3, "R9 read value", b, 8'hC3);
    chk(rx_empty == 1 && bus_rd_data == 0, "R9 empty after pop", bus_rd_data, 0);
    bus_read(b);
    chk(b == 0, "R9 empty read is zero", b, 0);
    rx_push(8'h3C); repeat (20) @(negedge clk);
    bus_read(b);
    chk(b == 8'h3C, "R9 empty read did not pop", b, 8'h3C);

    // R7/R8 fill and overrun
    for (int i = 0; i < 16; i++) rx_push(pat(i + 40));
    repeat (20) @(negedge clk);
    chk(rx_in_ready == 0, "R7 ready low when full", rx_in_ready, 0);
    chk(rx_overrun == 0, "R8 no overrun yet", rx_overrun, 0);
    rx_in_valid = 1; rx_in_data = 8'hFF; @(negedge clk); rx_in_valid = 0;
    chk(rx_overrun == 1, "R8 overrun set", rx_overrun, 1);
    for (int i = 0; i < 16; i++) begin
      for (int n = 0; n < 20 && rx_empty; n++) @(negedge clk);
      bus_read(b);
      chk(b == pat(i + 40), "R4 rx order", b, pat(i + 40));
    end
    repeat (20) @(negedge clk);
    chk(rx_empty == 1, "R8 dropped byte absent", rx_empty, 1);
    chk(rx_overrun == 1, "R8 overrun sticky", rx_overrun, 1);

    // R10 flush
    for (int i = 0; i < 3; i++) begin rx_push(pat(i)); tx_write(pat(i + 9)); end
    repeat (20) @(negedge clk);
    set_en(0);
    chk(!enabled && rx_empty && !rx_overrun, "R10 flush clears", {enabled, rx_empty, rx_overrun}, 3'b010);
    chk(rx_in_ready == 0, "R8 ready low while disabled", rx_in_ready, 0);
    rx_in_valid = 1; rx_in_data = 8'h11; @(negedge clk); rx_in_valid = 0;
    chk(rx_overrun == 0, "R8 no overrun while disabled", rx_overrun, 0);
    tx_write(8'h77); tx_write(8'h78);
    set_en(0);
    set_en(1);
    repeat (30) @(negedge clk);
    chk(tx_out_valid == 0, "R10 tx emptied by flush", tx_out_valid, 0);
    chk(rx_empty == 1, "R10 R8 rx empty", rx_empty, 1);

    // R4 random traffic
    void'($urandom(32'h2468ACE1));
    for (int c = 0; c < 4000; c++) begin
      bus_wr_en = ($urandom % 3) == 0; bus_wr_data = 8'($urandom);
      if (bus_wr_en && !tx_full) txq.push_back(bus_wr_data);
      tx_out_ready = ($urandom % 2) == 0;
      if (tx_out_valid && tx_out_ready) begin
        chk(txq.size() > 0 && tx_out_data == txq[0], "R4 R5 random tx", tx_out_data,
            txq.size() > 0 ? int'(txq[0]) : -1);
        if (txq.size() > 0) void'(txq.pop_front());
      end
      rx_in_valid = rx_in_ready && (($urandom % 3) == 0); rx_in_data = 8'($urandom);
      if (rx_in_valid) rxq.push_back(rx_in_data);
      bus_rd_en = ($urandom % 3) == 0;
      if (bus_rd_en && !rx_empty) begin
        chk(rxq.size() > 0 && bus_rd_data == rxq[0], "R4 R9 random rx", bus_rd_data,
            rxq.size() > 0 ? int'(rxq[0]) : -1);
        if (rxq.size() > 0) void'(rxq.pop_front());
      end
      @(negedge clk);
    end
    bus_wr_en = 0; rx_in_valid = 0; bus_rd_en = 0; tx_out_ready = 1;
    for (int c = 0; c < 100; c++) begin
      if (tx_out_valid) begin
        chk(txq.size() > 0 && tx_out_data == txq[0], "R4 drain tx", tx_out_data,
            txq.size() > 0 ? int'(txq[0]) : -1);
        if (txq.size() > 0) void'(txq.pop_front());
      end
      bus_rd_en = !rx_empty;
      if (!rx_empty) begin
        chk(rxq.size() > 0 && bus_rd_data == rxq[0], "R4 drain rx", bus_rd_data,
            rxq.size() > 0 ? int'(rxq[0]) : -1);
        if (rxq.size() > 0) void'(rxq.pop_front());
      end
      @(negedge clk);
    end
    bus_rd_en = 0; tx_out_ready = 0;
    chk(txq.size() == 0 && rxq.size() == 0, "R4 nothing lost", txq.size() + rxq.size(), 0);
    chk(rx_overrun == 0, "R7 no overrun with ready honoured", rx_overrun, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule